// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block programs a run of 16-bit words into a serial flash device using the device's auto-increment programming mode. A caller gives it an even start address and a word count with a one-cycle `start` pulse, then supplies the words one at a time on a valid/ready stream. The sequencer turns that into chip-select framed byte transfers for a byte-level SPI master. The master takes one byte at a time with `spi_tx_valid`/`spi_tx_ready` and returns the byte it shifted in on `spi_rx_valid`.

Every program run has the same shape. First the sequencer reads the status register until the device is idle. Then it sends write enable, followed by one program frame that carries the address and the first word. Each further word is preceded by more status polling and goes in a short frame that holds only the opcode and the data. A write-disable frame closes the run. Each status read is a separate frame, and chip select is released for at least one cycle between any two frames.

Top module: `aai_prog_seq`

## Requirements
- R1: After reset the block is idle: `spi_cs`, `spi_tx_valid`, `word_ready`, `active`, `done` and `err` are all low.
- R2: A run starts with status polling. Each poll is a two-byte frame: 0x05, then the fill byte 0x00. Polling repeats while bit 0 of the byte received for the fill byte is 1. All other received bits, and the byte received for the opcode, are ignored.
- R3: Once the device reports idle at the start of a run, the block sends a one-byte frame 0x06.
- R4: The first program frame is 0xAD, then the three address bytes with the most significant byte first, then the low byte and the high byte of the first word.
- R5: Every word after the first is preceded by its own status poll series, as in R2. It is sent in a frame of exactly three bytes: 0xAD, the low byte, then the high byte, with no address.
- R6: Chip select is low for at least one cycle between frames. `spi_tx_valid` is only high while chip select is high. After a byte is accepted, no further byte is offered until its received byte has returned.
- R7: After the frame carrying the last word, a one-byte frame 0x04 is sent. `done` then pulses for exactly one cycle and `active` falls.
- R8: `word_ready` is high only while the block waits for the next word, and exactly the requested number of words is taken per run.
- R9: A start with an odd address or a word count of zero raises `err` for exactly the cycle after the start. It produces no SPI traffic and takes no word.
- R10: A `start` pulse that arrives while a run is active is ignored. It raises no error and does not change the byte stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (sampled only when idle) |
| start_addr | input | 24 | Byte address of the first word |
| word_count | input | 16 | Number of 16-bit words to program |
| word_valid | input | 1 | A data word is offered |
| word_data | input | 16 | Data word, low byte goes to the lower address |
| word_ready | output | 1 | Block takes the offered word this cycle |
| spi_cs | output | 1 | Frame select to the SPI master, high inside a frame |
| spi_tx_valid | output | 1 | A byte to send is offered |
| spi_tx_byte | output | 8 | Byte to send |
| spi_tx_ready | input | 1 | SPI master accepts the offered byte |
| spi_rx_valid | input | 1 | Byte received for the last sent byte is present |
| spi_rx_byte | input | 8 | Received byte |
| active | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| err | output | 1 | One-cycle pulse for a rejected start |

## Verification
Every result has a fixed delay from the clock edge that causes it:
- `err` is high in the cycle after the edge that samples `start`.
- The first byte is offered in that same cycle.
- The next byte is offered one cycle after the edge that consumes a received byte, or two cycles when a frame ends, because of the one-cycle deselect gap.
- `done` follows one cycle after that gap when the gap ends the write-disable frame.

The bench drives all inputs on falling edges and samples on falling edges, so each output is read one half period after the edge that produced it. Its SPI model answers each accepted byte exactly one cycle later. A scoreboard compares every offered byte against a queue of expected bytes, each tagged with whether it opens a frame. This also checks where frames begin and end.

// File: rtl/aai_pkg.sv
package aai_pkg;
    localparam logic [7:0] OP_STATUS  = 8'h05;
    localparam logic [7:0] OP_WR_EN   = 8'h06;
    localparam logic [7:0] OP_WR_DIS  = 8'h04;
    localparam logic [7:0] OP_AUTOINC = 8'hAD;
    localparam logic [7:0] FILL_BYTE  = 8'h00;
    localparam logic [7:0] BUSY_MASK  = 8'h01;

    typedef enum logic [2:0] {
        FR_POLL, FR_WREN, FR_PROG_ADDR, FR_PROG_NEXT, FR_WRDIS
    } frame_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_SEND, ST_WAITRX, ST_GAP
    } state_e;
endpackage

// File: rtl/aai_frame_byte.sv
module aai_frame_byte
    import aai_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    localparam int IDX_W = $clog2(ADDR_BYTES + 4),
    localparam int ADDR_W = 8 * ADDR_BYTES
) (
    input  frame_e            kind,
    input  logic [IDX_W-1:0]  idx,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       word,
    output logic [7:0]        tx_byte,
    output logic              last
);
    always_comb begin
        tx_byte = FILL_BYTE;
        last    = 1'b1;
        unique case (kind)
            FR_POLL: begin
                tx_byte = (idx == '0) ? OP_STATUS : FILL_BYTE;
                last    = (int'(idx) == 1);
            end
            FR_WREN:  tx_byte = OP_WR_EN;
            FR_WRDIS: tx_byte = OP_WR_DIS;
            FR_PROG_ADDR: begin
                if (idx == '0) begin
                    tx_byte = OP_AUTOINC;
                end else if (int'(idx) == ADDR_BYTES + 1) begin
                    tx_byte = word[7:0];
                end else if (int'(idx) == ADDR_BYTES + 2) begin
                    tx_byte = word[15:8];
                end
                for (int k = 1; k <= ADDR_BYTES; k++) begin
                    if (int'(idx) == k) tx_byte = addr[8*(ADDR_BYTES-k) +: 8];
                end
                last = (int'(idx) == ADDR_BYTES + 2);
            end
            default: begin
                if (idx == '0)           tx_byte = OP_AUTOINC;
                else if (int'(idx) == 1) tx_byte = word[7:0];
                else                     tx_byte = word[15:8];
                last = (int'(idx) == 2);
            end
        endcase
    end
endmodule

// File: rtl/aai_word_cnt.sv
module aai_word_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [CNT_W-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (load)                    left_d = load_val;
        else if (dec && left_q != 0) left_d = left_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end

    assign zero = (left_q == '0);
endmodule

// File: rtl/aai_prog_seq.sv
module aai_prog_seq
    import aai_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int CNT_W      = 16,
    localparam int ADDR_W = 8 * ADDR_BYTES,
    localparam int IDX_W  = $clog2(ADDR_BYTES + 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  word_count,
    input  logic              word_valid,
    input  logic [15:0]       word_data,
    output logic              word_ready,
    output logic              spi_cs,
    output logic              spi_tx_valid,
    output logic [7:0]        spi_tx_byte,
    input  logic              spi_tx_ready,
    input  logic              spi_rx_valid,
    input  logic [7:0]        spi_rx_byte,
    output logic              active,
    output logic              done,
    output logic              err
);
    typedef struct packed {
        state_e            st;
        frame_e            kind;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] addr;
        logic [15:0]       word;
        logic              first;
        logic              busy;
        logic              done;
        logic              err;
    } seq_t;

    seq_t r_d, r_q;
    logic frame_last, cnt_load, cnt_dec, cnt_zero;

    aai_frame_byte #(.ADDR_BYTES(ADDR_BYTES)) u_frame (
        .kind(r_q.kind), .idx(r_q.idx), .addr(r_q.addr), .word(r_q.word),
        .tx_byte(spi_tx_byte), .last(frame_last)
    );

    aai_word_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(word_count),
        .dec(cnt_dec), .zero(cnt_zero)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: if (start) begin
                if (start_addr[0] || word_count == '0) begin
                    r_d.err = 1'b1;
                end else begin
                    r_d.addr  = start_addr;
                    r_d.first = 1'b1;
                    r_d.kind  = FR_POLL;
                    r_d.idx   = '0;
                    r_d.st    = ST_SEND;
                    cnt_load  = 1'b1;
                end
            end
            ST_FETCH: if (word_valid) begin
                r_d.word  = word_data;
                r_d.kind  = r_q.first ? FR_PROG_ADDR : FR_PROG_NEXT;
                r_d.first = 1'b0;
                r_d.idx   = '0;
                r_d.st    = ST_SEND;
                cnt_dec   = 1'b1;
            end
            ST_SEND: if (spi_tx_ready) r_d.st = ST_WAITRX;
            ST_WAITRX: if (spi_rx_valid) begin
                if (frame_last) begin
                    if (r_q.kind == FR_POLL)
                        r_d.busy = (spi_rx_byte & BUSY_MASK) != 8'h00;
                    r_d.st = ST_GAP;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                    r_d.st  = ST_SEND;
                end
            end
            default: begin
                r_d.idx = '0;
                r_d.st  = ST_SEND;
                unique case (r_q.kind)
                    FR_POLL: begin
                        if (r_q.busy)       r_d.kind = FR_POLL;
                        else if (r_q.first) r_d.kind = FR_WREN;
                        else                r_d.st   = ST_FETCH;
                    end
                    FR_WREN: r_d.st = ST_FETCH;
                    FR_WRDIS: begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end
                    default: r_d.kind = cnt_zero ? FR_WRDIS : FR_POLL;
                endcase
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, kind: FR_POLL, idx: '0, addr: '0, word: '0,
                     first: 1'b0, busy: 1'b0, done: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign spi_cs       = (r_q.st == ST_SEND) || (r_q.st == ST_WAITRX);
    assign spi_tx_valid = (r_q.st == ST_SEND);
    assign word_ready   = (r_q.st == ST_FETCH);
    assign active       = (r_q.st != ST_IDLE);
    assign done         = r_q.done;
    assign err          = r_q.err;

    assert_tx_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_tx_valid |-> spi_cs);
    assert_one_outstanding_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_tx_valid && spi_tx_ready) |=> !spi_tx_valid);
    assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!spi_cs && !active));
    assert_word_avail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ready && word_valid) |-> !cnt_zero);
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && start) |=> !err);
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!active && $past(active)));
endmodule

// File: tb/tb_aai_prog_seq.sv
`timescale 1ns/1ps
module tb_aai_prog_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] start_addr = '0;
    logic [15:0] word_count = '0;
    logic        word_valid = 1'b0;
    logic [15:0] word_data = '0;
    logic        word_ready;
    logic        spi_cs, spi_tx_valid;
    logic [7:0]  spi_tx_byte;
    logic        spi_tx_ready = 1'b1;
    logic        spi_rx_valid = 1'b0;
    logic [7:0]  spi_rx_byte = '0;
    logic        active, done, err;

    always #2 clk = ~clk;

    aai_prog_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .word_count(word_count), .word_valid(word_valid), .word_data(word_data),
        .word_ready(word_ready), .spi_cs(spi_cs), .spi_tx_valid(spi_tx_valid),
        .spi_tx_byte(spi_tx_byte), .spi_tx_ready(spi_tx_ready),
        .spi_rx_valid(spi_rx_valid), .spi_rx_byte(spi_rx_byte),
        .active(active), .done(done), .err(err)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [8:0]  exp_q[$];
    string       tag_q[$];
    logic [15:0] src_q[$];
    int busy_n = 0, busy_left = 0, src_gap = 0, gap_left = 0;
    bit stall_mode = 0;
    int stall_ph = 0, fpos = 0, done_cnt = 0, err_cnt = 0;
    int acc_cnt = 0, used = 0;
    bit pend = 0;
    logic [7:0] pend_byte = '0, fop = '0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    function automatic void push_exp(input bit f, input logic [7:0] b, input string tag);
        exp_q.push_back({f, b});
        tag_q.push_back(tag);
    endfunction

    function automatic void push_poll(input int bn, input string tag);
        for (int k = 0; k <= bn; k++) begin
            push_exp(1'b1, 8'h05, tag);
            push_exp(1'b0, 8'h00, tag);
        end
    endfunction

    // SPI byte master model and scoreboard monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            spi_rx_valid = 1'b0; pend = 0; fpos = 0; spi_tx_ready = 1'b1;
        end else begin
            stall_ph++;
            spi_tx_ready = stall_mode ? (stall_ph % 3 != 0) : 1'b1;
            spi_rx_valid = 1'b0;
            if (pend) begin spi_rx_valid = 1'b1; spi_rx_byte = pend_byte; pend = 0; end
            if (!spi_cs) fpos = 0;
            if (spi_tx_valid && !spi_cs) chk(0, "R6", "byte outside frame", 1, 0);
            if (spi_tx_valid && spi_tx_ready) begin
                logic [8:0] got, expv;
                string tg;
                if (fpos == 0) fop = spi_tx_byte;
                got = {fpos == 0, spi_tx_byte};
                if (exp_q.size() == 0) begin
                    chk(0, "R9", "unexpected byte", int'(got), 0);
                end else begin
                    expv = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    if (got[8] != expv[8]) chk(0, "R6", "frame boundary", int'(got), int'(expv));
                    else chk(got == expv, tg, "spi byte", int'(got), int'(expv));
                end
                if (fop == 8'h05 && fpos == 1) begin
                    if (busy_left > 0) begin busy_left--; pend_byte = 8'h41; end
                    else begin busy_left = busy_n; pend_byte = 8'h42; end
                end else begin
                    pend_byte = 8'hFF;
                end
                pend = 1;
                fpos++;
            end
            if (done) done_cnt++;
            if (err) err_cnt++;
        end
    end

    // word source
    always @(posedge clk) if (rst_n && word_valid && word_ready) acc_cnt <= acc_cnt + 1;
    always @(negedge clk) begin
        if (acc_cnt != used) begin
            used++;
            void'(src_q.pop_front());
            gap_left = src_gap;
        end
        if (gap_left > 0) begin
            gap_left--;
            word_valid = 1'b0;
        end else if (src_q.size() > 0) begin
            word_valid = 1'b1;
            word_data = src_q[0];
        end else begin
            word_valid = 1'b0;
        end
    end

    task automatic run_prog(input logic [23:0] a, input int n, input int bn, input int g,
                            input bit stall, input logic [15:0] seed, input bit disturb);
        int e0;
        int lim;
        bit seen;
        busy_n = bn; busy_left = bn; src_gap = g; stall_mode = stall;
        e0 = err_cnt;
        push_poll(bn, "R2");
        push_exp(1'b1, 8'h06, "R3");
        push_exp(1'b1, 8'hAD, "R4");
        push_exp(1'b0, a[23:16], "R4");
        push_exp(1'b0, a[15:8], "R4");
        push_exp(1'b0, a[7:0], "R4");
        for (int i = 0; i < n; i++) begin
            logic [15:0] w;
            w = seed + 16'(i) * 16'h1357;
            if (i > 0) begin
                push_poll(bn, "R5");
                push_exp(1'b1, 8'hAD, "R5");
            end
            push_exp(1'b0, w[7:0], i > 0 ? "R5" : "R4");
            push_exp(1'b0, w[15:8], i > 0 ? "R5" : "R4");
            src_q.push_back(w);
        end
        push_exp(1'b1, 8'h04, "R7");
        @(negedge clk);
        start = 1'b1; start_addr = a; word_count = 16'(n);
        @(negedge clk);
        start = 1'b0;
        seen = 0;
        lim = 0;
        while (!seen && lim < 20000) begin
            @(negedge clk);
            lim++;
            if (disturb && lim == 30) begin start = 1'b1; start_addr = 24'h000001; end
            if (disturb && lim == 31) start = 1'b0;
            if (done) seen = 1;
        end
        chk(seen, "R7", "done seen", int'(seen), 1);
        chk(exp_q.size() == 0, "R7", "bytes left at done", exp_q.size(), 0);
        chk(!active, "R7", "active at done", int'(active), 0);
        @(negedge clk);
        chk(!done, "R7", "done width", int'(done), 0);
        chk(src_q.size() == 0, "R8", "words left", src_q.size(), 0);
        chk(!word_ready, "R8", "ready when idle", int'(word_ready), 0);
        chk(err_cnt == e0, "R10", "err during run", err_cnt - e0, 0);
        exp_q.delete(); tag_q.delete();
        stall_mode = 0;
    endtask

    task automatic run_bad(input logic [23:0] a, input logic [15:0] n);
        src_q.push_back(16'hBEEF);
        src_gap = 0;
        @(negedge clk);
        start = 1'b1; start_addr = a; word_count = n;
        @(negedge clk);
        start = 1'b0;
        chk(err, "R9", "err pulse", int'(err), 1);
        chk(!active && !spi_cs, "R9", "quiet on error", int'(active | spi_cs), 0);
        @(negedge clk);
        chk(!err, "R9", "err width", int'(err), 0);
        repeat (10) begin
            @(negedge clk);
            if (word_ready || spi_cs) chk(0, "R9", "activity after reject", 1, 0);
        end
        chk(src_q.size() == 1, "R9", "word taken", src_q.size(), 1);
        src_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!spi_cs && !spi_tx_valid && !word_ready && !active && !done && !err,
            "R1", "reset outputs", int'({spi_cs, spi_tx_valid, word_ready, active, done, err}), 0);
        run_prog(24'h012344, 1, 0, 0, 0, 16'hA1B2, 0);
        run_prog(24'hABCDE0, 4, 2, 3, 1, 16'h3C5A, 0);
        run_prog(24'h00F002, 3, 0, 0, 0, 16'h7E01, 1);
        run_bad(24'h000101, 16'd2);
        run_bad(24'h000100, 16'd0);
        run_prog(24'h000100, 8, 1, 1, 1, 16'h0F0F, 0);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule